// File: doc/BRIEF.md
# Receive Packet Framer with Tag Echo

This block gathers inbound converter samples, each a 32-bit word holding a 16-bit I value and a 16-bit Q value, into fixed 512-byte packets for a USB bridge. A packet is 128 words. Two header words come first. The rest of the packet holds 126 sample words. The header carries the sample-counter timestamp of the packet's first sample and the tag most recently seen on the outbound stream. It also carries two sticky status bits: receive overrun and transmit underrun. Because these bits travel inside the packet, no dedicated status pins are needed.

Storage is double-buffered, so one packet can fill while the previous one waits or is read out. When a packet is complete, `pkt_avail` rises. The bridge then reads the packet one word at a time: `rd_data` shows the current word, and `rd_en` moves to the next word. A sample that arrives while both buffers hold unread packets is dropped, and the next completed header reports the loss.

Top module: `rx_pkt_framer`

## Requirements
- R1: A packet is 128 words read in order: word 0 is the timestamp, word 1 is the status word, and words 2 to 127 are samples. Bits [15:0] of the status word hold the payload length, 504.
- R2: Word 0 equals the `smp_time` value present in the cycle in which the packet's first sample was accepted.
- R3: Bits [31:24] of the status word hold the last `out_tag` value presented with `out_tag_valid`, up to and including the cycle in which the packet's last sample was accepted. The value after reset is 0.
- R4: Sample words appear in words 2 to 127 in the order the samples were accepted, with no gaps.
- R5: `pkt_avail` is high while a complete packet is waiting. Each cycle with `rd_en` high advances one word. After word 127 is read, the next waiting packet is offered, or `pkt_avail` falls if no packet is waiting.
- R6: While one complete packet waits unread, a second packet can fill. Both packets are then read out in the order they were completed.
- R7: A sample offered while both buffers hold complete packets is dropped. Status bit [23] (overrun) is set in the next packet that completes, and is clear in the packet after that unless a new drop occurs.
- R8: A `tx_underrun` pulse sets status bit [22] in the next packet that completes, and the bit is clear in later packets. Status bits [21:16] are zero.
- R9: After reset, `pkt_avail` is low.
- R10: `rd_en` has no effect while `pkt_avail` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample is offered this cycle |
| smp_data | input | 32 | Sample word: I in [31:16], Q in [15:0] |
| smp_time | input | 32 | Free-running sample counter |
| out_tag_valid | input | 1 | A tag was seen on the outbound stream |
| out_tag | input | 8 | The outbound tag value |
| tx_underrun | input | 1 | Transmit underrun event pulse |
| pkt_avail | output | 1 | A complete packet can be read |
| rd_en | input | 1 | Advance to the next packet word |
| rd_data | output | 32 | Current packet word |

## Verification
A fault in the fill side shows up as a shifted or repeated sample word, or as a wrong timestamp, in the very packet being built. The bench therefore compares every word of every packet it reads. A fault in the sticky status bits shows in the header of the next completed packet, or in the one after it, and the bench checks both headers in sequence. A fault in buffer ownership shows as a packet lost or repeated under back-pressure, or as `pkt_avail` staying high or falling too early. The bench checks this flag at each packet boundary.

// File: rtl/rx_pkt_framer.sv
module rx_pkt_framer #(
  parameter int SAMPLES = 126
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_valid,
  input  logic [31:0] smp_data,
  input  logic [31:0] smp_time,
  input  logic        out_tag_valid,
  input  logic [7:0]  out_tag,
  input  logic        tx_underrun,
  output logic        pkt_avail,
  input  logic        rd_en,
  output logic [31:0] rd_data
);
  localparam int WORDS = SAMPLES + 2;
  localparam int IW = $clog2(WORDS);
  localparam logic [15:0] PAY_BYTES = 16'(SAMPLES * 4);

  logic [31:0]   mem [2][SAMPLES];
  logic [31:0]   ts_q [2];
  logic [31:0]   w1_q [2];
  logic [1:0]    full;
  logic          wr_buf, rd_buf;
  logic [IW-1:0] wr_idx, rd_idx, sidx;
  logic [7:0]    tag_q;
  logic          ovr_q, und_q;

  wire accept  = smp_valid && !full[wr_buf];
  wire drop    = smp_valid && full[wr_buf];
  wire last_wr = accept && (wr_idx == IW'(SAMPLES - 1));
  wire rd_go   = rd_en && full[rd_buf];
  wire last_rd = rd_go && (rd_idx == IW'(WORDS - 1));
  wire [7:0] tag_now = out_tag_valid ? out_tag : tag_q;
  wire [31:0] hdr_w1 = {tag_now, ovr_q, und_q | tx_underrun, 6'b0, PAY_BYTES};

  assign pkt_avail = full[rd_buf];
  assign sidx = (rd_idx >= IW'(2)) ? rd_idx - IW'(2) : '0;
  assign rd_data = (rd_idx == '0) ? ts_q[rd_buf] :
                   (rd_idx == IW'(1)) ? w1_q[rd_buf] : mem[rd_buf][sidx];

  always_ff @(posedge clk)
    if (accept) mem[wr_buf][wr_idx] <= smp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= '0;
      wr_buf <= 1'b0;
      rd_buf <= 1'b0;
      wr_idx <= '0;
      rd_idx <= '0;
      tag_q  <= '0;
      ovr_q  <= 1'b0;
      und_q  <= 1'b0;
      ts_q   <= '{default: '0};
      w1_q   <= '{default: '0};
    end else begin
      if (out_tag_valid) tag_q <= out_tag;
      if (accept && wr_idx == '0) ts_q[wr_buf] <= smp_time;
      if (accept) wr_idx <= last_wr ? '0 : wr_idx + IW'(1);
      if (last_wr) begin
        w1_q[wr_buf] <= hdr_w1;
        full[wr_buf] <= 1'b1;
        wr_buf       <= ~wr_buf;
      end
      if (drop) ovr_q <= 1'b1;
      else if (last_wr) ovr_q <= 1'b0;
      und_q <= last_wr ? 1'b0 : (und_q | tx_underrun);
      if (rd_go) rd_idx <= last_rd ? '0 : rd_idx + IW'(1);
      if (last_rd) begin
        full[rd_buf] <= 1'b0;
        rd_buf       <= ~rd_buf;
      end
    end
  end

  assert_rd_idx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx <= IW'(WORDS - 1));
  assert_ts_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wr_idx == '0) |=> (ts_q[$past(wr_buf)] == $past(smp_time)));
  assert_wrap_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_rd |=> (rd_idx == '0));
  assert_drop_flags_ovr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovr_q);
  assert_drop_holds_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> $stable(wr_idx));
  assert_rd_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !pkt_avail) |=> $stable(rd_idx) && $stable(rd_buf));
endmodule

// File: tb/rx_pkt_framer_tb_top.sv
module rx_pkt_framer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [31:0] smp_data = '0;
  logic [31:0] smp_time = '0;
  logic out_tag_valid = 1'b0;
  logic [7:0] out_tag = '0;
  logic tx_underrun = 1'b0;
  logic rd_en = 1'b0;
  logic pkt_avail;
  logic [31:0] rd_data;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;
  always @(posedge clk) smp_time <= smp_time + 32'd1;

  rx_pkt_framer dut_i (.clk, .rst_n, .smp_valid, .smp_data, .smp_time,
    .out_tag_valid, .out_tag, .tx_underrun, .pkt_avail, .rd_en, .rd_data);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] smp(int k);
    return {16'(k), 16'hA000 ^ 16'(k)};
  endfunction

  task automatic push(int k, output logic [31:0] t);
    smp_valid = 1'b1;
    smp_data = smp(k);
    t = smp_time;
    @(posedge clk); @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic fill_pkt(int base, output logic [31:0] ts);
    logic [31:0] t;
    for (int i = 0; i < 126; i++) begin
      push(base + i, t);
      if (i == 0) ts = t;
    end
  endtask

  task automatic read_pkt(string tag_req, logic [31:0] ts, logic [7:0] tag,
                          logic ovr, logic und, int base);
    check("R5 pkt_avail before read", {31'b0, pkt_avail}, 32'd1);
    rd_en = 1'b1;
    for (int w = 0; w < 128; w++) begin
      if (w == 0) check("R2 timestamp", rd_data, ts);
      else if (w == 1) begin
        check(tag_req, {24'b0, rd_data[31:24]}, {24'b0, tag});
        check("R7 overrun bit", {31'b0, rd_data[23]}, {31'b0, ovr});
        check("R8 underrun bit", {31'b0, rd_data[22]}, {31'b0, und});
        check("R8 reserved", {26'b0, rd_data[21:16]}, 32'd0);
        check("R1 length", {16'b0, rd_data[15:0]}, 32'd504);
      end else check("R4 sample order", rd_data, smp(base + w - 2));
      @(posedge clk); @(negedge clk);
    end
    rd_en = 1'b0;
  endtask

  task automatic pulse_tag(logic [7:0] v);
    out_tag_valid = 1'b1; out_tag = v;
    @(posedge clk); @(negedge clk);
    out_tag_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R9 pkt_avail after reset", {31'b0, pkt_avail}, 32'd0);
    rd_en = 1'b1;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    rd_en = 1'b0;
    check("R10 rd_en ignored, still empty", {31'b0, pkt_avail}, 32'd0);
  endtask

  task automatic t_basic();
    logic [31:0] ts;
    pulse_tag(8'h5A);
    fill_pkt(100, ts);
    read_pkt("R3 tag", ts, 8'h5A, 1'b0, 1'b0, 100);
    check("R5 pkt_avail after read", {31'b0, pkt_avail}, 32'd0);
  endtask

  task automatic t_tag_underrun();
    logic [31:0] ts, t;
    for (int i = 0; i < 126; i++) begin
      if (i == 60) begin out_tag_valid = 1'b1; out_tag = 8'hC3; tx_underrun = 1'b1; end
      push(2000 + i, t);
      out_tag_valid = 1'b0; tx_underrun = 1'b0;
      if (i == 0) ts = t;
    end
    read_pkt("R3 latest tag", ts, 8'hC3, 1'b0, 1'b1, 2000);
    fill_pkt(3000, ts);
    read_pkt("R3 tag held", ts, 8'hC3, 1'b0, 1'b0, 3000);
  endtask

  task automatic t_backpressure();
    logic [31:0] ta, tb, tc, td, t;
    fill_pkt(4000, ta);
    fill_pkt(5000, tb);
    check("R6 both held", {31'b0, pkt_avail}, 32'd1);
    for (int i = 0; i < 3; i++) push(9000 + i, t);
    read_pkt("R6 first packet tag", ta, 8'hC3, 1'b0, 1'b0, 4000);
    read_pkt("R6 second packet tag", tb, 8'hC3, 1'b0, 1'b0, 5000);
    check("R5 drained", {31'b0, pkt_avail}, 32'd0);
    fill_pkt(6000, tc);
    read_pkt("R7 tag after drop", tc, 8'hC3, 1'b1, 1'b0, 6000);
    fill_pkt(7000, td);
    read_pkt("R7 tag next", td, 8'hC3, 1'b0, 1'b0, 7000);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_tag_underrun();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule